// File: doc/BRIEF.md
# Interrupt sequencing controller

This controller sits next to a simple instruction sequencer and decides, each time the sequencer reports that an instruction has finished, whether control passes to an interrupt handler. Four request lines are watched for rising edges. Each edge is held in a pending latch until the controller takes that source. When a source is taken, the controller pushes the current program counter and the running priority level onto a small context stack. It then asks the sequencer to jump to that source's handler address, which comes from a vector table given at its input.

A return strobe from the handler pops the stack. The controller then asks the sequencer to resume at the saved address, and the priority level drops back to the saved one. A mode input picks one of two behaviours. In sequential mode, a running handler is never interrupted. In nested mode, a strictly more urgent source may preempt the running handler, which resumes when the more urgent handler returns. A global enable blocks all entries but does not stop requests from being latched.

Top module: `intr_seq_ctrl`

## Requirements
- R1: After reset, `redirectValid` is 0, `ackOut` is 0, `activeLevel` is 4 (the idle value) and no request is pending.
- R2: A rising edge on `irqLines[i]` sets a pending latch for source i. The latch stays set until that source is taken. A line held high does not set it again.
- R3: Entry happens only at an edge where `boundary` is 1. In the cycle after that edge: `redirectValid` is 1, `redirectPc` equals the source's vector `vecTable[16*i +: 16]`, `ackOut` is one-hot with bit i set, and `activeLevel` equals i. A request whose edge coincides with the boundary edge is first considered at the next boundary.
- R4: Source 0 has the highest priority and source 3 the lowest. When several sources are pending, the lowest index is taken.
- R5: On an edge where `retStrobe` is 1 and the stack holds an entry, the cycle after shows `redirectValid` 1, `redirectPc` equal to the saved PC, `ackOut` 0, and `activeLevel` equal to the saved level. A return with an empty stack has no effect.
- R6: With `nestMode` 0 and a handler running, no entry is made for any source. Requests keep pending and are taken at the first boundary after the handler returns.
- R7: With `nestMode` 1, a pending source with a strictly lower index than `activeLevel` preempts at a boundary. A source of equal or higher index waits until the handler returns.
- R8: With `globalEn` 0 no entry is made, but rising edges still set pending latches. Those requests are taken once the enable is set again.
- R9: The stack holds four contexts. Four nested entries (levels 3, 2, 1, 0) unwind in reverse order on four returns.
- R10: In a cycle with `retStrobe` 1, no entry is made, even if `boundary` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqLines | input | 4 | Request lines; index 0 is most urgent |
| vecTable | input | 64 | Handler addresses, 16 bits per source, source i at bits 16*i+15:16*i |
| curPc | input | 16 | Address of the next instruction, saved on entry |
| boundary | input | 1 | The current instruction has finished |
| retStrobe | input | 1 | Return from the running handler |
| nestMode | input | 1 | 0 sequential handling, 1 priority nesting |
| globalEn | input | 1 | Allows entries when 1 |
| redirectValid | output | 1 | One-cycle request to load `redirectPc` |
| redirectPc | output | 16 | Handler address or resume address |
| ackOut | output | 4 | One-hot acknowledge of the source taken |
| activeLevel | output | 3 | Level of the running handler, 4 when idle |

## Verification
Every entry and return result appears in the cycle after the clock edge that samples `boundary` or `retStrobe`. A request needs one edge to reach its pending latch, so it can be taken no earlier than the following boundary edge. The bench changes inputs on the falling edge and compares the outputs on the next falling edge, so each comparison sees exactly the one rising edge that acted on the inputs just applied. Outputs that are held between events, such as `activeLevel`, are compared on every vector. This shows that requests which are ignored, blocked or not yet due leave the level and the redirect untouched.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  localparam int IRQ_NUM     = 4;
  localparam int PC_W        = 16;
  localparam int STACK_DEPTH = 4;
  localparam int SRC_W       = $clog2(IRQ_NUM);
  localparam int LVL_W       = $clog2(IRQ_NUM + 1);
  localparam int SP_W        = $clog2(STACK_DEPTH + 1);
  localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'(IRQ_NUM);

  typedef struct packed {
    logic             push;
    logic             pop;
    logic [SRC_W-1:0] src;
  } ctl_strobe_t;
endpackage

// File: rtl/intr_prio_pick.sv
module intr_prio_pick
  import intr_seq_pkg::*;
(
  input  logic [IRQ_NUM-1:0] reqVec,
  output logic               anyHit,
  output logic [SRC_W-1:0]   pickIdx
);
  always_comb begin
    anyHit  = 1'b0;
    pickIdx = '0;
    for (int i = IRQ_NUM - 1; i >= 0; i--) begin
      if (reqVec[i]) begin
        anyHit  = 1'b1;
        pickIdx = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/intr_seq_ctrl_fsm.sv
module intr_seq_ctrl_fsm
  import intr_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [IRQ_NUM-1:0] irqLines,
  input  logic               boundary,
  input  logic               retStrobe,
  input  logic               nestMode,
  input  logic               globalEn,
  input  logic [LVL_W-1:0]   curLevel,
  input  logic               stackFull,
  input  logic               stackEmpty,
  output ctl_strobe_t        strobe
);
  logic [IRQ_NUM-1:0] reqPrev;
  logic [IRQ_NUM-1:0] pending;
  logic [IRQ_NUM-1:0] riseVec;
  logic [IRQ_NUM-1:0] takeMask;
  logic               candHit;
  logic [SRC_W-1:0]   candIdx;
  logic               isIdle;
  logic               candHigher;
  logic               allowed;
  logic               doPush;

  assign riseVec = irqLines & ~reqPrev;

  intr_prio_pick u_pick (
    .reqVec (pending),
    .anyHit (candHit),
    .pickIdx(candIdx)
  );

  assign isIdle     = (curLevel == IDLE_LVL);
  assign candHigher = (LVL_W'(candIdx) < curLevel);
  assign allowed    = isIdle | (nestMode & candHigher);
  assign doPush     = boundary & ~retStrobe & globalEn & candHit & allowed & ~stackFull;
  assign takeMask   = doPush ? (IRQ_NUM'(1) << candIdx) : '0;

  always_comb begin
    strobe.push = doPush;
    strobe.pop  = retStrobe & ~stackEmpty;
    strobe.src  = candIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev <= '0;
      pending <= '0;
    end else begin
      reqPrev <= irqLines;
      pending <= (pending & ~takeMask) | riseVec;
    end
  end

  // A latched request disappears only when its source is taken
  assert_pending_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.push |=> (($past(pending) & ~pending) == '0));

  // No entry from a return cycle
  assert_ret_blocks_entry_R10: assert property (@(posedge clk) disable iff (!rstN)
    retStrobe |-> !strobe.push);

  // A disabled controller never enters
  assert_enable_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !strobe.push);
endmodule

// File: rtl/intr_seq_ctx_path.sv
module intr_seq_ctx_path
  import intr_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctl_strobe_t           strobe,
  input  logic [IRQ_NUM*PC_W-1:0] vecTable,
  input  logic [PC_W-1:0]       curPc,
  input  logic                  nestMode,
  output logic [LVL_W-1:0]      curLevel,
  output logic                  stackFull,
  output logic                  stackEmpty,
  output logic                  redirectValid,
  output logic [PC_W-1:0]       redirectPc,
  output logic [IRQ_NUM-1:0]    ackOut
);
  logic [PC_W-1:0]  stackPc  [STACK_DEPTH];
  logic [LVL_W-1:0] stackLvl [STACK_DEPTH];
  logic [SP_W-1:0]  sp;
  logic [SP_W-1:0]  topIdx;
  logic [PC_W-1:0]  vecSel;

  assign stackFull  = (sp == SP_W'(STACK_DEPTH));
  assign stackEmpty = (sp == '0);
  assign topIdx     = sp - SP_W'(1);
  assign vecSel     = vecTable[strobe.src*PC_W +: PC_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp            <= '0;
      curLevel      <= IDLE_LVL;
      redirectValid <= 1'b0;
      redirectPc    <= '0;
      ackOut        <= '0;
      for (int i = 0; i < STACK_DEPTH; i++) begin
        stackPc[i]  <= '0;
        stackLvl[i] <= '0;
      end
    end else begin
      redirectValid <= 1'b0;
      ackOut        <= '0;
      if (strobe.pop) begin
        sp            <= topIdx;
        curLevel      <= stackLvl[topIdx[$clog2(STACK_DEPTH)-1:0]];
        redirectPc    <= stackPc[topIdx[$clog2(STACK_DEPTH)-1:0]];
        redirectValid <= 1'b1;
      end else if (strobe.push) begin
        stackPc[sp[$clog2(STACK_DEPTH)-1:0]]  <= curPc;
        stackLvl[sp[$clog2(STACK_DEPTH)-1:0]] <= curLevel;
        sp            <= sp + SP_W'(1);
        curLevel      <= LVL_W'(strobe.src);
        redirectPc    <= vecSel;
        redirectValid <= 1'b1;
        ackOut        <= IRQ_NUM'(1) << strobe.src;
      end
    end
  end

  // Stack depth is never exceeded
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (sp < SP_W'(STACK_DEPTH)));

  // Returns only consume saved contexts
  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> (sp != '0));

  // Preemption of a running handler needs nested mode and a more urgent source
  assert_preempt_rule_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && curLevel != IDLE_LVL) |-> (nestMode && LVL_W'(strobe.src) < curLevel));

  // Entry yields a redirect with a single acknowledge bit in the next cycle
  assert_entry_redirect_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> (redirectValid && $onehot0(ackOut) && ackOut != '0));

  assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackOut));
endmodule

// File: rtl/intr_seq_ctrl.sv
module intr_seq_ctrl
  import intr_seq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [IRQ_NUM-1:0]      irqLines,
  input  logic [IRQ_NUM*PC_W-1:0] vecTable,
  input  logic [PC_W-1:0]         curPc,
  input  logic                    boundary,
  input  logic                    retStrobe,
  input  logic                    nestMode,
  input  logic                    globalEn,
  output logic                    redirectValid,
  output logic [PC_W-1:0]         redirectPc,
  output logic [IRQ_NUM-1:0]      ackOut,
  output logic [LVL_W-1:0]        activeLevel
);
  ctl_strobe_t      strobe;
  logic [LVL_W-1:0] curLevel;
  logic             stackFull;
  logic             stackEmpty;

  intr_seq_ctrl_fsm u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .irqLines  (irqLines),
    .boundary  (boundary),
    .retStrobe (retStrobe),
    .nestMode  (nestMode),
    .globalEn  (globalEn),
    .curLevel  (curLevel),
    .stackFull (stackFull),
    .stackEmpty(stackEmpty),
    .strobe    (strobe)
  );

  intr_seq_ctx_path u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .vecTable     (vecTable),
    .curPc        (curPc),
    .nestMode     (nestMode),
    .curLevel     (curLevel),
    .stackFull    (stackFull),
    .stackEmpty   (stackEmpty),
    .redirectValid(redirectValid),
    .redirectPc   (redirectPc),
    .ackOut       (ackOut)
  );

  assign activeLevel = curLevel;
endmodule

// File: tb/intr_seq_ctrl_bench.sv
module intr_seq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  irqLines = '0;
  logic [63:0] vecTable;
  logic [15:0] curPc = '0;
  logic        boundary = 1'b0;
  logic        retStrobe = 1'b0;
  logic        nestMode = 1'b0;
  logic        globalEn = 1'b0;
  logic        redirectValid;
  logic [15:0] redirectPc;
  logic [3:0]  ackOut;
  logic [2:0]  activeLevel;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  assign vecTable = {16'h1300, 16'h1200, 16'h1100, 16'h1000};

  intr_seq_ctrl u_intr_seq_ctrl (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .vecTable(vecTable),
    .curPc(curPc), .boundary(boundary), .retStrobe(retStrobe),
    .nestMode(nestMode), .globalEn(globalEn), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .ackOut(ackOut), .activeLevel(activeLevel)
  );

  typedef struct packed {
    logic [3:0]  irq;
    logic        bnd;
    logic        ret;
    logic        nest;
    logic        en;
    logic [15:0] pc;
    logic        expV;
    logic [15:0] expPc;
    logic [2:0]  expLvl;
    logic [3:0]  expAck;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t TABLE [NV] = '{
    // sequential mode
    '{4'b0010, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000, 3'd4, 4'b0000, 4'd2},  // R2 latch
    '{4'b0010, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0040, 1'b1, 16'h1100, 3'd1, 4'b0010, 4'd3},  // R3 entry
    '{4'b0001, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000, 3'd1, 4'b0000, 4'd2},
    '{4'b0001, 1'b1, 1'b0, 1'b0, 1'b1, 16'h1104, 1'b0, 16'h0000, 3'd1, 4'b0000, 4'd6},  // R6 no preempt
    '{4'b0001, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0040, 3'd4, 4'b0000, 4'd5},  // R5 return
    '{4'b0001, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0044, 1'b1, 16'h1000, 3'd0, 4'b0001, 4'd6},  // R6 taken after return
    '{4'b0001, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0044, 3'd4, 4'b0000, 4'd5},
    '{4'b0000, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0048, 1'b0, 16'h0000, 3'd4, 4'b0000, 4'd2},  // R2 held line no repend
    // nested mode, full depth
    '{4'b1000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h0000, 3'd4, 4'b0000, 4'd2},
    '{4'b1000, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0100, 1'b1, 16'h1300, 3'd3, 4'b1000, 4'd3},
    '{4'b1100, 1'b1, 1'b0, 1'b1, 1'b1, 16'h1302, 1'b0, 16'h0000, 3'd3, 4'b0000, 4'd3},  // R3 same-edge request waits
    '{4'b1100, 1'b1, 1'b0, 1'b1, 1'b1, 16'h1304, 1'b1, 16'h1200, 3'd2, 4'b0100, 4'd7},  // R7 preempt
    '{4'b1110, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h0000, 3'd2, 4'b0000, 4'd2},
    '{4'b1111, 1'b1, 1'b0, 1'b1, 1'b1, 16'h1204, 1'b1, 16'h1100, 3'd1, 4'b0010, 4'd7},
    '{4'b1111, 1'b1, 1'b0, 1'b1, 1'b1, 16'h1108, 1'b1, 16'h1000, 3'd0, 4'b0001, 4'd9},  // R9 fourth level
    '{4'b0000, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b1, 16'h1108, 3'd1, 4'b0000, 4'd9},  // R9 unwind
    '{4'b0000, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b1, 16'h1204, 3'd2, 4'b0000, 4'd9},
    '{4'b0000, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b1, 16'h1304, 3'd3, 4'b0000, 4'd9},
    '{4'b0000, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b1, 16'h0100, 3'd4, 4'b0000, 4'd9},
    '{4'b0000, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h0000, 3'd4, 4'b0000, 4'd5},  // R5 empty return ignored
    // nested mode, equal and lower priority
    '{4'b0100, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h0000, 3'd4, 4'b0000, 4'd2},
    '{4'b0100, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0200, 1'b1, 16'h1200, 3'd2, 4'b0100, 4'd3},
    '{4'b0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h0000, 3'd2, 4'b0000, 4'd2},
    '{4'b0100, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h0000, 3'd2, 4'b0000, 4'd2},
    '{4'b0100, 1'b1, 1'b0, 1'b1, 1'b1, 16'h1202, 1'b0, 16'h0000, 3'd2, 4'b0000, 4'd7},  // R7 equal waits
    '{4'b1100, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h0000, 3'd2, 4'b0000, 4'd2},
    '{4'b1100, 1'b1, 1'b0, 1'b1, 1'b1, 16'h1204, 1'b0, 16'h0000, 3'd2, 4'b0000, 4'd7},  // R7 lower waits
    '{4'b1100, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b1, 16'h0200, 3'd4, 4'b0000, 4'd5},
    '{4'b1100, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0300, 1'b1, 16'h1200, 3'd2, 4'b0100, 4'd4},  // R4 index 2 before 3
    '{4'b1100, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b1, 16'h0300, 3'd4, 4'b0000, 4'd5},
    '{4'b1100, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0304, 1'b1, 16'h1300, 3'd3, 4'b1000, 4'd4},
    '{4'b1100, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b1, 16'h0304, 3'd4, 4'b0000, 4'd5},
    // global enable
    '{4'b0001, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 3'd4, 4'b0000, 4'd8},
    '{4'b0001, 1'b1, 1'b0, 1'b1, 1'b0, 16'h03F0, 1'b0, 16'h0000, 3'd4, 4'b0000, 4'd8},  // R8 blocked
    '{4'b0001, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0400, 1'b1, 16'h1000, 3'd0, 4'b0001, 4'd8},  // R8 kept pending
    '{4'b0001, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b1, 16'h0400, 3'd4, 4'b0000, 4'd5},
    // return and boundary together
    '{4'b0010, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000, 3'd4, 4'b0000, 4'd2},
    '{4'b0010, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0500, 1'b0, 16'h0000, 3'd4, 4'b0000, 4'd10}, // R10
    '{4'b0010, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0504, 1'b1, 16'h1100, 3'd1, 4'b0010, 4'd10},
    '{4'b0010, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0504, 3'd4, 4'b0000, 4'd5}
  };

  task automatic checkOut(input string tag, input logic expV, input logic [15:0] expPc,
                          input logic [2:0] expLvl, input logic [3:0] expAck);
    total++;
    if (redirectValid !== expV || (expV && redirectPc !== expPc) ||
        activeLevel !== expLvl || ackOut !== expAck) begin
      bad++;
      $display("FAIL %s: got valid=%0b pc=%h lvl=%0d ack=%b, expected valid=%0b pc=%h lvl=%0d ack=%b",
               tag, redirectValid, redirectPc, activeLevel, ackOut, expV, expPc, expLvl, expAck);
    end
  endtask

  task automatic idleInputs();
    boundary  = 1'b0;
    retStrobe = 1'b0;
    curPc     = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog: got cycles=%0d, expected below 20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    globalEn = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    checkOut("R1 in reset", 1'b0, 16'h0, 3'd4, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after release", 1'b0, 16'h0, 3'd4, 4'b0000);

    for (int k = 0; k < NV; k++) begin
      irqLines  = TABLE[k].irq;
      boundary  = TABLE[k].bnd;
      retStrobe = TABLE[k].ret;
      nestMode  = TABLE[k].nest;
      globalEn  = TABLE[k].en;
      curPc     = TABLE[k].pc;
      @(negedge clk);
      checkOut($sformatf("R%0d vector %0d", TABLE[k].req, k),
               TABLE[k].expV, TABLE[k].expPc, TABLE[k].expLvl, TABLE[k].expAck);
    end

    // R1 reset clears a latched request
    idleInputs();
    irqLines = 4'b0000;
    @(negedge clk);
    irqLines = 4'b0100;
    @(negedge clk);
    irqLines = 4'b0000;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    boundary = 1'b1;
    curPc = 16'h0600;
    @(negedge clk);
    checkOut("R1 pending cleared by reset", 1'b0, 16'h0, 3'd4, 4'b0000);
    idleInputs();
    @(negedge clk);

    // R4 simultaneous edges, lowest index first, sequential mode
    nestMode = 1'b0;
    irqLines = 4'b1010;
    @(negedge clk);
    boundary = 1'b1;
    curPc = 16'h0700;
    @(negedge clk);
    checkOut("R4 two pending, index 1 first", 1'b1, 16'h1100, 3'd1, 4'b0010);
    boundary = 1'b0;
    retStrobe = 1'b1;
    @(negedge clk);
    checkOut("R5 resume", 1'b1, 16'h0700, 3'd4, 4'b0000);
    retStrobe = 1'b0;
    boundary = 1'b1;
    curPc = 16'h0704;
    @(negedge clk);
    checkOut("R4 remaining index 3", 1'b1, 16'h1300, 3'd3, 4'b1000);
    idleInputs();
    @(negedge clk);
    checkOut("R3 redirect lasts one cycle", 1'b0, 16'h0, 3'd3, 4'b0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule